// File: doc/BRIEF.md
# Serial Flash Page-Program Engine

This block is the device-side command logic of a serial NOR flash for the page-program operation. It watches an active-low chip select and a serial clock, and it shifts in an opcode, a 24-bit address and one or more data bytes. The single-line form carries everything on `sio[0]`. The four-line form carries the opcode on `sio[0]`, then the address and data on all four lines. Data bytes collect in a 256-byte page buffer whose write pointer starts at the low address byte and wraps within the page, so only the most recent 256 bytes survive.

When chip select rises cleanly after at least one whole data byte, and the page is writable, the buffered bytes are ANDed into a behavioural memory array. A timed program cycle then starts. During that cycle the write-in-progress flag reads 1, and when it ends both the flag and the write-enable latch clear. The serial inputs are oversampled by the system clock, so the serial clock must stay at least two system clocks in each level.

Top module: `pp_engine`

## Requirements
- R1: After reset, `wip` and `wel` are 0 and every array byte reads 0xFF.
- R2: A program command that starts while `wel` is 0 is ignored: the array, `wip` and `wel` stay unchanged.
- R3: Opcode 0x02 selects single-line mode. The opcode, the three address bytes (most significant byte first) and the data bytes are shifted in MSB first from `sio[0]`, one bit per rising `sck` while `cs_n` is low. Consecutive data bytes go to consecutive offsets starting at address bits 7..0. Array location = address modulo the array size.
- R4: When the data pointer passes offset 255, it wraps to offset 0 of the same page.
- R5: When more than 256 data bytes are sent, the array receives only the final 256 bytes.
- R6: Bytes of the page that no data byte addressed keep their previous contents.
- R7: The command is rejected with no array change and no program cycle if `cs_n` rises after a bit count that is not a whole number of bytes, or before any complete data byte.
- R8: An accepted command raises `wip` one clock after `cs_n` is sampled high. `wip` stays 1 for exactly `PROG_CYCLES` clocks, and `wel` clears in the clock where `wip` falls. A rejected command leaves `wel` set.
- R9: `bp` holding value k > 0 protects the top k pages of the array (all pages when k ≥ the page count). A program aimed at a protected page is rejected.
- R10: Opcode 0x32 selects four-line mode and is accepted only while `quad_en` is 1. Address and data then move one nibble per rising `sck`: the high nibble comes first and `sio[3]` is the most significant bit of the nibble.
- R11: Programming ANDs each new byte into the stored byte, so bits only move toward 0.
- R12: A program command whose opcode completes while `wip` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock; inputs are taken on its rising edge |
| sio | input | 4 | Serial data lines; single-line mode uses bit 0 |
| wren | input | 1 | One-clock pulse that sets the write-enable latch |
| quad_en | input | 1 | Permits the four-line program opcode |
| bp | input | 4 | Block-protect level |
| rd_addr | input | AW | Array byte address for read-back |
| rd_data | output | 8 | Array byte at `rd_addr` |
| wip | output | 1 | Write in progress |
| wel | output | 1 | Write-enable latch |

## Verification
On every clock, the assertions check the following. A commit happens only with the latch set and the engine idle. A commit is followed by a busy cycle. The latch is clear whenever busy falls. Four-line framing is never entered without the quad enable. The bench's scenarios alone can show the data effects: wrap-around inside the page, survival of only the last 256 bytes, untouched neighbours, the AND behaviour, and the rejection of commands that are misframed, protected, or sent while busy. For these, the bench reads the whole array back and compares it against its own model.

// File: rtl/pp_pkg.sv
package pp_pkg;
    localparam int unsigned PAGE_BYTES = 256;
    localparam logic [7:0]  OP_PROG_1  = 8'h02;
    localparam logic [7:0]  OP_PROG_4  = 8'h32;

    typedef enum logic [1:0] {PH_OPC, PH_ADDR, PH_DATA, PH_SKIP} phase_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] off;
        logic [7:0] data;
    } wbyte_t;

    function automatic logic page_locked(input logic [3:0] lvl, input int unsigned page,
                                         input int unsigned npages);
        return (lvl != 4'd0) && ((npages - 1 - page) < int'(lvl));
    endfunction
endpackage

// File: rtl/pp_frontend.sv
module pp_frontend
    import pp_pkg::*;
#(
    parameter int unsigned NUM_PAGES = 4,
    localparam int unsigned PB = $clog2(NUM_PAGES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          sck,
    input  logic [3:0]    sio,
    input  logic          wel,
    input  logic          busy,
    input  logic          quad_en,
    input  logic [3:0]    bp,
    output wbyte_t        wb,
    output logic          clr,
    output logic          commit,
    output logic [PB-1:0] page
);
    logic        sck_q, cs_q, quad, got_data;
    phase_t      phase;
    logic [7:0]  sh, nsh, ptr;
    logic [3:0]  bits, nbits;
    logic [1:0]  abytes;
    logic [23:0] addr;
    logic        sck_rise, byte_done, wide;

    assign wide      = quad && (phase != PH_OPC);
    assign sck_rise  = sck && !sck_q && !cs_n;
    assign nbits     = bits + (wide ? 4'd4 : 4'd1);
    assign nsh       = wide ? {sh[3:0], sio} : {sh[6:0], sio[0]};
    assign byte_done = (nbits == 4'd8);
    assign clr       = !cs_n && cs_q;
    assign page      = addr[8 +: PB];
    assign commit    = cs_n && !cs_q && (phase == PH_DATA) && got_data && (bits == 4'd0)
                       && !page_locked(bp, int'(page), NUM_PAGES);

    always_comb begin
        wb.valid = sck_rise && byte_done && (phase == PH_DATA);
        wb.off   = ptr;
        wb.data  = nsh;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0; cs_q <= 1'b1; phase <= PH_OPC; quad <= 1'b0;
            sh <= '0; bits <= '0; abytes <= '0; addr <= '0; ptr <= '0; got_data <= 1'b0;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
            if (cs_n) begin
                phase <= PH_OPC; quad <= 1'b0; bits <= '0; abytes <= '0; got_data <= 1'b0;
            end else if (sck_rise) begin
                sh   <= nsh;
                bits <= byte_done ? 4'd0 : nbits;
                if (byte_done) begin
                    case (phase)
                        PH_OPC: begin
                            if (!busy && wel && (nsh == OP_PROG_1 || (nsh == OP_PROG_4 && quad_en))) begin
                                phase <= PH_ADDR;
                                quad  <= (nsh == OP_PROG_4);
                            end else begin
                                phase <= PH_SKIP;
                            end
                        end
                        PH_ADDR: begin
                            addr   <= {addr[15:0], nsh};
                            abytes <= abytes + 2'd1;
                            if (abytes == 2'd2) begin
                                phase <= PH_DATA;
                                ptr   <= nsh;
                            end
                        end
                        PH_DATA: begin
                            ptr      <= ptr + 8'd1;
                            got_data <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    AST_QUAD_NEEDS_QE: assert property (@(posedge clk) disable iff (rst)
        $rose(quad) |-> $past(quad_en)); // R10
endmodule

// File: rtl/pp_pagebuf.sv
module pp_pagebuf
    import pp_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  wbyte_t                      wb,
    output logic [PAGE_BYTES-1:0][7:0]  pdata,
    output logic [PAGE_BYTES-1:0]       pmask
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pmask <= '0;
        end else if (wb.valid) begin
            pmask[wb.off] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wb.valid) pdata[wb.off] <= wb.data;
    end
endmodule

// File: rtl/pp_array.sv
module pp_array
    import pp_pkg::*;
#(
    parameter int unsigned NUM_PAGES = 4,
    localparam int unsigned PB    = $clog2(NUM_PAGES),
    localparam int unsigned NB    = NUM_PAGES * PAGE_BYTES,
    localparam int unsigned AW    = $clog2(NB)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       commit,
    input  logic [PB-1:0]              page,
    input  logic [PAGE_BYTES-1:0][7:0] pdata,
    input  logic [PAGE_BYTES-1:0]      pmask,
    input  logic [AW-1:0]              rd_addr,
    output logic [7:0]                 rd_data
);
    logic [7:0] mem [NB];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(NB); i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            for (int i = 0; i < int'(PAGE_BYTES); i++) begin
                if (pmask[i]) mem[{page, i[7:0]}] <= mem[{page, i[7:0]}] & pdata[i];
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/pp_engine.sv
module pp_engine
    import pp_pkg::*;
#(
    parameter int unsigned NUM_PAGES   = 4,
    parameter int unsigned PROG_CYCLES = 1000,
    localparam int unsigned PB = $clog2(NUM_PAGES),
    localparam int unsigned AW = $clog2(NUM_PAGES * PAGE_BYTES),
    localparam int unsigned CW = $clog2(PROG_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          sck,
    input  logic [3:0]    sio,
    input  logic          wren,
    input  logic          quad_en,
    input  logic [3:0]    bp,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          wip,
    output logic          wel
);
    wbyte_t                      wb;
    logic                        clr, commit;
    logic [PB-1:0]               page;
    logic [PAGE_BYTES-1:0][7:0]  pdata;
    logic [PAGE_BYTES-1:0]       pmask;
    logic [CW-1:0]               cnt;

    pp_frontend #(.NUM_PAGES(NUM_PAGES)) u_fe (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sio(sio), .wel(wel), .busy(wip),
        .quad_en(quad_en), .bp(bp), .wb(wb), .clr(clr), .commit(commit), .page(page));

    pp_pagebuf u_buf (
        .clk(clk), .rst(rst), .clr(clr), .wb(wb), .pdata(pdata), .pmask(pmask));

    pp_array #(.NUM_PAGES(NUM_PAGES)) u_arr (
        .clk(clk), .rst(rst), .commit(commit), .page(page), .pdata(pdata), .pmask(pmask),
        .rd_addr(rd_addr), .rd_data(rd_data));

    assign wip = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            wel <= 1'b0;
        end else begin
            if (commit)          cnt <= CW'(PROG_CYCLES);
            else if (cnt != '0)  cnt <= cnt - 1'b1;
            if (cnt == CW'(1))   wel <= 1'b0;
            else if (wren)       wel <= 1'b1;
        end
    end

    AST_COMMIT_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
        commit |-> wel); // R2
    AST_COMMIT_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        commit |-> !wip); // R12
    AST_COMMIT_STARTS_WIP: assert property (@(posedge clk) disable iff (rst)
        commit |=> wip); // R8
    AST_WIP_END_CLEARS_WEL: assert property (@(posedge clk) disable iff (rst)
        $fell(wip) |-> !wel); // R8
endmodule

// File: tb/pp_engine_test.sv
`timescale 1ns/1ps
module pp_engine_test;
    localparam int NP   = 4;
    localparam int PROG = 2000;
    localparam int NB   = NP * 256;

    logic       clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sck = 1'b0, wren = 1'b0, quad_en = 1'b0;
    logic [3:0] sio = 4'h0, bp = 4'h0;
    logic [9:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       wip, wel;

    int tests = 0, fails = 0;
    int m_cnt = 0;
    logic m_wel = 1'b0, m_arm = 1'b0, cs_prev = 1'b1;
    byte unsigned m_mem [NB];

    pp_engine #(.NUM_PAGES(NP), .PROG_CYCLES(PROG)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sio(sio), .wren(wren), .quad_en(quad_en),
        .bp(bp), .rd_addr(rd_addr), .rd_data(rd_data), .wip(wip), .wel(wel));

    always #2 clk = ~clk;

    // Reference model of busy timer and latch, advanced on every clock
    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= 0; m_wel <= 1'b0; cs_prev <= 1'b1;
        end else begin
            cs_prev <= cs_n;
            if (cs_n && !cs_prev && m_arm) m_cnt <= PROG;
            else if (m_cnt > 0) m_cnt <= m_cnt - 1;
            if (m_cnt == 1) m_wel <= 1'b0;
            else if (wren) m_wel <= 1'b1;
        end
    end

    // Per-clock comparison (R8)
    always @(negedge clk) begin
        if (!rst) begin
            tests++;
            if (wip !== (m_cnt != 0) || wel !== m_wel) begin
                fails++;
                $display("FAIL R8 clock compare: wip=%0b wel=%0b expected wip=%0b wel=%0b",
                         wip, wel, m_cnt != 0, m_wel);
            end
        end
    end

    initial begin
        #(4 * 190000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_mem(input string req);
        int bad = 0;
        tests++;
        for (int i = 0; i < NB; i++) begin
            @(negedge clk) rd_addr = 10'(i);
            #1;
            if (rd_data !== m_mem[i]) begin
                if (bad < 4) $display("FAIL %s: addr %0h actual=%0h expected=%0h", req, i, rd_data, m_mem[i]);
                bad++;
            end
        end
        if (bad > 0) fails++;
    endtask

    task automatic sbit(input logic [3:0] v);
        @(negedge clk) sio = v;
        repeat (2) @(negedge clk);
        sck = 1'b1;
        repeat (2) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic sbyte(input logic [7:0] b, input logic four);
        if (four) begin
            sbit(b[7:4]); sbit(b[3:0]);
        end else begin
            for (int i = 7; i >= 0; i--) sbit({3'b000, b[i]});
        end
    endtask

    task automatic pulse_wren();
        @(negedge clk) wren = 1'b1;
        @(negedge clk) wren = 1'b0;
    endtask

    task automatic wait_idle();
        while (wip) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_cmd(input logic [7:0] op, input logic [23:0] a, input int n,
                           input logic [7:0] seed, input int extra);
        logic four, ok, locked;
        int pg;
        logic [7:0] pbuf [256];
        logic       pmsk [256];
        logic [7:0] ptr;
        four   = (op == 8'h32);
        pg     = int'(a[9:8]);
        locked = (bp != 0) && ((NP - 1 - pg) < int'(bp));
        ok     = m_wel && (m_cnt == 0) && (op == 8'h02 || (four && quad_en))
                 && (n >= 1) && (extra == 0) && !locked;
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
        sbyte(op, 1'b0);
        sbyte(a[23:16], four); sbyte(a[15:8], four); sbyte(a[7:0], four);
        for (int i = 0; i < 256; i++) pmsk[i] = 1'b0;
        ptr = a[7:0];
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = seed + 8'(i * 7);
            sbyte(d, four);
            pbuf[ptr] = d; pmsk[ptr] = 1'b1; ptr++;
        end
        for (int i = 0; i < extra; i++) sbit(4'h1);
        repeat (2) @(negedge clk);
        m_arm = ok;
        cs_n  = 1'b1;
        @(negedge clk) m_arm = 1'b0;
        if (ok) for (int i = 0; i < 256; i++)
            if (pmsk[i]) m_mem[pg * 256 + i] = m_mem[pg * 256 + i] & pbuf[i];
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int wcount;
        for (int i = 0; i < NB; i++) m_mem[i] = 8'hFF;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 wip after reset", wip, 0);
        check("R1 wel after reset", wel, 0);
        check_mem("R1 array erased");

        run_cmd(8'h02, 24'h000010, 2, 8'h12, 0);            // no latch
        check("R2 wip stays low", wip, 0);
        check_mem("R2 array untouched");

        pulse_wren();
        check("R8 wel set", wel, 1);
        run_cmd(8'h02, 24'h000005, 3, 8'hA5, 0);
        check("R8 wip raised", wip, 1);
        wcount = 0;
        while (wip) begin @(negedge clk); wcount++; end
        check("R8 wip length near PROG", (wcount > PROG - 20 && wcount <= PROG) ? 1 : 0, 1);
        check("R8 wel cleared at end", wel, 0);
        check_mem("R3 R6 single-line bytes");

        pulse_wren();
        run_cmd(8'h02, 24'h0001FE, 4, 8'h30, 0);
        wait_idle();
        check_mem("R4 wrap inside page");

        pulse_wren();
        run_cmd(8'h02, 24'h000240, 260, 8'h01, 0);
        wait_idle();
        check_mem("R5 last 256 bytes kept");

        pulse_wren();
        run_cmd(8'h02, 24'h000020, 2, 8'h00, 3);
        check("R7 misframed no wip", wip, 0);
        check("R8 wel kept after reject", wel, 1);
        run_cmd(8'h02, 24'h000020, 0, 8'h00, 0);
        check("R7 no data no wip", wip, 0);
        check_mem("R7 array untouched");

        bp = 4'd1;
        run_cmd(8'h02, 24'h000300, 2, 8'h00, 0);
        check("R9 protected page no wip", wip, 0);
        check_mem("R9 protected page untouched");
        run_cmd(8'h02, 24'h000280, 2, 8'h44, 0);
        wait_idle();
        check_mem("R9 unprotected page programmed");
        bp = 4'd0;

        pulse_wren();
        run_cmd(8'h32, 24'h000100, 2, 8'h5A, 0);
        check("R10 quad without enable rejected", wip, 0);
        quad_en = 1'b1;
        run_cmd(8'h32, 24'h000108, 3, 8'h5A, 0);
        wait_idle();
        check_mem("R10 four-line bytes");
        quad_en = 1'b0;

        pulse_wren();
        run_cmd(8'h02, 24'h000005, 1, 8'h0F, 0);
        check("R12 busy phase started", wip, 1);
        pulse_wren();
        run_cmd(8'h02, 24'h000006, 1, 8'h00, 0);
        wait_idle();
        check_mem("R11 R12 AND and busy ignore");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule